// File: doc/BRIEF.md
# Delta-RGB 8-bit Pixel Serializer

This block takes one 24-bit RGB pixel at a time from a pixel stream and sends it to an 8-bit panel data bus. Each pixel goes out as three byte-wide beats on consecutive dot-clock cycles, so a line of N pixels takes 3N dot clocks on the output. A byte-valid strobe marks the three beats and stays low during blanking.

The order of the three colour components is chosen per line. Odd lines use one order code and even lines use another, and each code picks one of six permutations. A delta-arranged panel is driven with R,G,B on odd lines and G,B,R on even lines. A plain serial panel uses R,G,B on every line. The order word comes from a host-written register. The block captures it only at frame start and tracks line parity from the line-start pulses.

Top module: `rgb_delta_serializer`

## Requirements
- R1: A pixel carries R in bits [23:16], G in [15:8] and B in [7:0]. An accepted pixel appears on `byte_out` as three beats on the three cycles after acceptance, in the active order: code 0 = R,G,B; 1 = R,B,G; 2 = G,R,B; 3 = G,B,R; 4 = B,R,G; 5 = B,G,R. The first-named component goes first. `byte_valid` is high on all three beats.
- R2: In the order word, bits [6:4] hold the odd-line code and bits [2:0] hold the even-line code. Bits 7 and 3 are ignored.
- R3: A code of 6 or 7 makes that line parity use R,G,B order.
- R4: `frame_start` sets the parity to even, so the next `line_start` begins line 1, which is odd. Each `line_start` toggles the parity. When both pulses arrive in the same cycle, `frame_start` wins.
- R5: The order word is captured only in a cycle with `frame_start` high. A change at any other time has no effect until the next frame start.
- R6: `pix_ready` is high when no pixel is in flight, and on the last beat of a pixel. It is low on the other beats and in any cycle with `line_start` or `frame_start` high. Pixels offered back to back produce an unbroken byte stream at three cycles per pixel.
- R7: `line_start` or `frame_start` aborts a pixel in flight. `byte_valid` is low the next cycle, and the next pixel begins with its line's first component.
- R8: Whenever `byte_valid` is low, `byte_out` is zero.
- R9: After reset, `byte_valid` is 0, `byte_out` is 0 and `pix_ready` is 1. The order word reads as all zeros, so both parities use R,G,B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame-start pulse |
| line_start | input | 1 | One-cycle line-start pulse |
| order_word | input | 8 | Host order word: odd code [6:4], even code [2:0] |
| pix_valid | input | 1 | Input pixel present |
| pix_data | input | 24 | Input pixel {R,G,B} |
| pix_ready | output | 1 | Pixel accepted when high with `pix_valid` |
| byte_out | output | 8 | Panel data byte |
| byte_valid | output | 1 | High on each of the three beats of a pixel |

## Verification
A wrong beat index shows as a swapped or repeated component on the very next byte. It can also show as a gap in the byte stream or a `pix_ready` pulse off its three-cycle rhythm within one pixel time. A parity flip that is lost or doubled puts the odd-line order on an even line, which is visible on the first byte after the next `line_start`. A captured word that changes mid-frame, or a reserved code that is not mapped to R,G,B, shows on the first pixel of the line that uses it. The sweep covers every odd/even code pair over three lines, so each of these faults surfaces within a few dozen cycles of its cause.

// File: rtl/rgb_delta_serializer.sv
module rgb_delta_serializer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic [7:0]    order_word,
  input  logic          pix_valid,
  input  logic [3*CW-1:0] pix_data,
  output logic          pix_ready,
  output logic [CW-1:0] byte_out,
  output logic          byte_valid
);

  logic [3*CW-1:0] pix_q;
  logic            act;
  logic [1:0]      beat;
  logic            line_odd;
  logic [2:0]      code_odd, code_even;
  logic [2:0]      code_now;
  logic [1:0]      comp;
  logic            take;

  function automatic logic [2:0] clean(input logic [2:0] c);
    return (c > 3'd5) ? 3'd0 : c;
  endfunction

  // comp: 0 = R, 1 = G, 2 = B
  function automatic logic [1:0] pick(input logic [2:0] c, input logic [1:0] b);
    logic [5:0] seq;
    case (c)
      3'd1:    seq = {2'd0, 2'd2, 2'd1};
      3'd2:    seq = {2'd1, 2'd0, 2'd2};
      3'd3:    seq = {2'd1, 2'd2, 2'd0};
      3'd4:    seq = {2'd2, 2'd0, 2'd1};
      3'd5:    seq = {2'd2, 2'd1, 2'd0};
      default: seq = {2'd0, 2'd1, 2'd2};
    endcase
    case (b)
      2'd0:    return seq[5:4];
      2'd1:    return seq[3:2];
      default: return seq[1:0];
    endcase
  endfunction

  assign pix_ready = !frame_start && !line_start && (!act || beat == 2'd2);
  assign take      = pix_ready && pix_valid;
  assign code_now  = line_odd ? code_odd : code_even;
  assign comp      = pick(code_now, beat);

  always_comb begin
    byte_out = '0;
    if (act) begin
      case (comp)
        2'd0:    byte_out = pix_q[3*CW-1:2*CW];
        2'd1:    byte_out = pix_q[2*CW-1:CW];
        default: byte_out = pix_q[CW-1:0];
      endcase
    end
  end

  assign byte_valid = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_odd  <= '0;
      code_even <= '0;
      line_odd  <= 1'b0;
    end else if (frame_start) begin
      code_odd  <= clean(order_word[6:4]);
      code_even <= clean(order_word[2:0]);
      line_odd  <= 1'b0;
    end else if (line_start) begin
      line_odd  <= !line_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      beat  <= '0;
      pix_q <= '0;
    end else if (frame_start || line_start) begin
      act   <= 1'b0;
      beat  <= '0;
    end else if (take) begin
      act   <= 1'b1;
      beat  <= '0;
      pix_q <= pix_data;
    end else if (act) begin
      if (beat == 2'd2) act <= 1'b0;
      else beat <= beat + 2'd1;
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> byte_valid) else $error("accept"); // R1
  AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) && !line_start && !frame_start |=> byte_valid) else $error("burst"); // R6
  AST_ABORT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    line_start || frame_start |=> !byte_valid) else $error("abort"); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(code_odd) && $stable(code_even)) else $error("cfg"); // R5
  AST_PARITY_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !frame_start |=> line_odd != $past(line_odd)) else $error("parity"); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> byte_out == '0) else $error("idle"); // R8
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    code_odd < 3'd6 && code_even < 3'd6) else $error("code"); // R3

endmodule

// File: tb/rgb_delta_serializer_tb.sv
module rgb_delta_serializer_tb;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, line_start = 0, pix_valid = 0;
  logic [7:0] order_word = 0;
  logic [23:0] pix_data = 0;
  logic pix_ready, byte_valid;
  logic [7:0] byte_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rgb_delta_serializer u_dut (.clk, .rst_n, .frame_start, .line_start, .order_word,
    .pix_valid, .pix_data, .pix_ready, .byte_out, .byte_valid);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [23:0] p, input int code, input int b);
    int first, lo, hi, c;
    if (code > 5) code = 0;
    first = code / 2;
    lo = (first == 0) ? 1 : 0;
    hi = (first == 2) ? 1 : 2;
    if (b == 0) c = first;
    else if (b == 1) c = (code % 2) ? hi : lo;
    else c = (code % 2) ? lo : hi;
    return p[23 - 8*c -: 8];
  endfunction

  function automatic logic [23:0] mkpix(input int a);
    return {8'(a), 8'(a + 85), 8'(a + 170)};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_frame(input logic [7:0] w);
    frame_start = 1; order_word = w; step(); frame_start = 0;
  endtask

  task automatic pulse_line();
    line_start = 1;
    #1 chk("R6 ready low on line_start", pix_ready, 0);
    step(); line_start = 0;
  endtask

  task automatic send_line(input int n, input int code, input int seed, input string req);
    logic [23:0] p;
    p = mkpix(seed);
    pix_valid = 1; pix_data = p;
    #1 chk("R6 ready idle", pix_ready, 1);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 3; b++) begin
        step();
        chk({req, " valid"}, byte_valid, 1);
        chk({req, " byte"}, byte_out, exp_byte(p, code, b));
        chk("R6 ready cadence", pix_ready, (b == 2));
        if (b == 2) begin
          if (k < n - 1) begin p = mkpix(seed + k + 1); pix_data = p; end
          else pix_valid = 0;
        end
      end
    end
    step();
    chk("R8 blank valid", byte_valid, 0);
    chk("R8 blank zero", byte_out, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    chk("R9 reset valid", byte_valid, 0);
    chk("R9 reset byte", byte_out, 0);
    chk("R9 reset ready", pix_ready, 1);
    rst_n = 1;
    step();
    // R9: no frame_start yet, zero word -> RGB
    pulse_line();
    send_line(1, 0, 3, "R9 default order");

    // R1 R2 R3 R4: sweep every odd/even code pair
    for (int o = 0; o < 8; o++) begin
      for (int e = 0; e < 8; e++) begin
        pulse_frame({1'b1, 3'(o), 1'b1, 3'(e)});
        pulse_line();
        send_line(2, o, o * 16 + e, "R1 R2 R3 odd line1");
        pulse_line();
        send_line(2, e, o * 16 + e + 40, "R4 even line2");
        pulse_line();
        send_line(1, o, o * 16 + e + 80, "R4 odd line3");
      end
    end

    // R5: mid-frame word change ignored
    pulse_frame(8'h03);
    pulse_line();
    order_word = 8'h54;
    send_line(1, 0, 9, "R5 odd keeps old");
    pulse_line();
    send_line(1, 3, 10, "R5 even keeps old");
    pulse_frame(8'h54);
    pulse_line();
    send_line(1, 5, 11, "R5 new after frame");

    // R4: simultaneous pulses -> frame wins, next line odd
    frame_start = 1; line_start = 1; order_word = 8'h21; step();
    frame_start = 0; line_start = 0;
    pulse_line();
    send_line(1, 2, 12, "R4 frame priority");

    // R7: abort mid-pixel
    pulse_line();
    pix_valid = 1; pix_data = mkpix(50);
    step();
    chk("R7 first beat", byte_out, exp_byte(mkpix(50), 1, 0));
    line_start = 1; step(); line_start = 0;
    chk("R7 aborted valid", byte_valid, 0);
    pix_data = mkpix(60);
    step();
    chk("R7 restart valid", byte_valid, 1);
    chk("R7 restart first comp", byte_out, exp_byte(mkpix(60), 2, 0));
    step();
    chk("R7 restart second comp", byte_out, exp_byte(mkpix(60), 2, 1));
    pix_valid = 0;
    step(); step();
    chk("R8 idle after abort test", byte_valid, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule